// File: doc/BRIEF.md
# Indexed Register Host Interface for a Graphics Display Controller

This block sits between an 8-bit host bus and the rest of a dot-matrix display controller. The host has a chip select, a register select, and separate write and read strobes. With register select low it writes a pointer that names one of 18 data registers. With register select high it reaches the register that the pointer names. Only three of those registers act inside this block: a control byte, the display-memory address counter and the display-memory data port. Writes to the other indices are dropped here.

The host strobes are asynchronous to the block clock. Each strobe goes through a two-stage synchronizer, and a rising edge of the write strobe commits the write. Through the data port the host reads and writes an internal display RAM. The address counter steps after each access. In read-modify-write mode a read leaves the address alone, so a read followed by a write lands on the same byte. The control byte is decoded into discrete outputs. One of them, the segment-flip bit, mirrors the column index that the scan logic presents.

Top module: `disp_host_regfile`

## Requirements
- R1: After the active-low reset every decoded output is 0, `dout` is 0 and the register pointer is 0. The pointer value is seen through the first data write, which lands in the control byte.
- R2: A write with `rs` low loads the pointer from `din[4:0]`. Bits 7 to 5 are ignored, so 0xE0 selects index 0.
- R3: Index 0 is the control byte. Its bits, from 7 down to 0, are: read-modify-write enable, display enable, standby, power pin, amplifier enable, reverse, halt and segment flip. `pwr_pin`, `amp_en`, `reverse`, `halt`, `seg_flip` and `standby` follow their bits directly.
- R4: `disp_on` is high only when the display-enable bit is 1 and the standby bit is 0.
- R5: Writing index 1 loads the address counter. Writing index 2 stores `din` in RAM at the counter and then adds 1 to the counter.
- R6: Reading index 2 returns the RAM byte at the counter on `dout` while the read strobe is low. With read-modify-write off, the counter adds 1 when the strobe rises.
- R7: With read-modify-write on (control bit 7 = 1), a read leaves the counter unchanged. A following write updates that same byte and then adds 1 to the counter.
- R8: The 8-bit counter wraps from 0xFF to 0x00 on an increment.
- R9: Writes to indices 18 to 31 change nothing. Reading the pointer or any index other than 2 returns 0x00 and changes nothing.
- R10: `seg_idx` equals `scan_col` when segment flip is 0, and 159 minus `scan_col` when it is 1.
- R11: Strobes with `cs_n` high change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | 0 selects the pointer, 1 selects the data register the pointer names |
| wr_n | input | 1 | Write strobe, active low; the rising edge commits the write |
| rd_n | input | 1 | Read strobe, active low |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| scan_col | input | 8 | Column index from the scan logic |
| seg_idx | output | 8 | Column index after optional mirroring |
| disp_on | output | 1 | Display enabled and not in standby |
| standby | output | 1 | Standby bit |
| pwr_pin | output | 1 | External power-control level |
| amp_en | output | 1 | Amplifier enable |
| reverse | output | 1 | Reverse-video bit |
| halt | output | 1 | Halt bit |
| seg_flip | output | 1 | Segment direction bit |

## Verification
The assertions take it for granted that the host holds `cs_n`, `rs` and `din` stable from before a strobe falls until several clocks after it rises. They also assume that a write strobe and a read strobe never overlap. The bench keeps to this: every access sets the select and data lines two clocks ahead of the strobe, holds the strobe for three to six clocks, and changes nothing for six clocks after the strobe rises. Every check is taken on a falling clock edge after that settling window.

// File: rtl/disp_host_regfile.sv
module disp_host_regfile #(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int NSEG     = 160,
  parameter int NREG     = 18,
  parameter int CTRL_IDX = 0,
  parameter int ADDR_IDX = 1,
  parameter int MEM_IDX  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rs,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic [AW-1:0] scan_col,
  output logic [AW-1:0] seg_idx,
  output logic          disp_on,
  output logic          standby,
  output logic          pwr_pin,
  output logic          amp_en,
  output logic          reverse,
  output logic          halt,
  output logic          seg_flip
);
  localparam int IW = $clog2(NREG);
  localparam int DEPTH = 1 << AW;
  localparam logic [IW-1:0] CTRL_I = IW'(CTRL_IDX);
  localparam logic [IW-1:0] ADDR_I = IW'(ADDR_IDX);
  localparam logic [IW-1:0] MEM_I  = IW'(MEM_IDX);
  localparam logic [AW-1:0] LAST_SEG = AW'(NSEG - 1);

  logic [2:0]    wr_sy, rd_sy;
  logic [IW-1:0] idx_q;
  logic [7:0]    ctrl_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] dout_q;
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_sy <= 3'b111;
      rd_sy <= 3'b111;
    end else begin
      wr_sy <= {wr_sy[1:0], wr_n};
      rd_sy <= {rd_sy[1:0], rd_n};
    end

  logic wr_evt, rd_evt, rd_act, mem_sel, rmw_on;
  assign wr_evt  = wr_sy[1] & ~wr_sy[2] & ~cs_n;
  assign rd_evt  = rd_sy[1] & ~rd_sy[2] & ~cs_n;
  assign rd_act  = ~rd_sy[1] & ~cs_n;
  assign mem_sel = rs && (idx_q == MEM_I);
  assign rmw_on  = ctrl_q[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx_q  <= '0;
      ctrl_q <= '0;
      addr_q <= '0;
      dout_q <= '0;
    end else begin
      dout_q <= (rd_act && mem_sel) ? ram[addr_q] : '0;
      if (wr_evt) begin
        if (!rs)
          idx_q <= din[IW-1:0];
        else if (idx_q == CTRL_I)
          ctrl_q <= din[7:0];
        else if (idx_q == ADDR_I)
          addr_q <= din[AW-1:0];
        else if (idx_q == MEM_I)
          addr_q <= addr_q + 1'b1;
      end else if (rd_evt && mem_sel && !rmw_on) begin
        addr_q <= addr_q + 1'b1;
      end
    end

  always_ff @(posedge clk)
    if (wr_evt && mem_sel) ram[addr_q] <= din;

  assign dout     = dout_q;
  assign disp_on  = ctrl_q[6] & ~ctrl_q[5];
  assign standby  = ctrl_q[5];
  assign pwr_pin  = ctrl_q[4];
  assign amp_en   = ctrl_q[3];
  assign reverse  = ctrl_q[2];
  assign halt     = ctrl_q[1];
  assign seg_flip = ctrl_q[0];
  assign seg_idx  = seg_flip ? LAST_SEG - scan_col : scan_col;
endmodule

// File: rtl/disp_host_regfile_chk.sv
module disp_host_regfile_chk #(
  parameter int AW   = 8,
  parameter int NSEG = 160
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_evt,
  input logic          rd_evt,
  input logic          mem_sel,
  input logic          rmw_on,
  input logic [AW-1:0] addr_q,
  input logic [AW-1:0] scan_col,
  input logic [AW-1:0] seg_idx,
  input logic [6:0]    outs
);
  p_wr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && mem_sel |=> addr_q == AW'($past(addr_q) + 1'b1));

  p_rd_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt && mem_sel && !rmw_on && !wr_evt |=> addr_q == AW'($past(addr_q) + 1'b1));

  p_rmw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt && mem_sel && rmw_on && !wr_evt |=> $stable(addr_q));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt && !rd_evt |=> $stable(addr_q));

  p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> $stable(outs));

  p_seg_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scan_col < AW'(NSEG) |-> seg_idx < AW'(NSEG));
endmodule

bind disp_host_regfile disp_host_regfile_chk #(.AW(AW), .NSEG(NSEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
  .mem_sel(mem_sel), .rmw_on(rmw_on), .addr_q(addr_q),
  .scan_col(scan_col), .seg_idx(seg_idx),
  .outs({disp_on, standby, pwr_pin, amp_en, reverse, halt, seg_flip})
);

// File: tb/sim_disp_host_regfile.sv
module sim_disp_host_regfile;
  logic clk = 0, rst_n = 0, cs_n = 1, rs = 0, wr_n = 1, rd_n = 1;
  logic [7:0] din = 0, scan_col = 0;
  logic [7:0] dout, seg_idx;
  logic disp_on, standby, pwr_pin, amp_en, reverse, halt, seg_flip;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  disp_host_regfile u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .wr_n(wr_n), .rd_n(rd_n),
    .din(din), .dout(dout), .scan_col(scan_col), .seg_idx(seg_idx),
    .disp_on(disp_on), .standby(standby), .pwr_pin(pwr_pin), .amp_en(amp_en),
    .reverse(reverse), .halt(halt), .seg_flip(seg_flip));

  wire [6:0] ovec = {disp_on, standby, pwr_pin, amp_en, reverse, halt, seg_flip};

  // {control byte, expected {disp_on,standby,pwr,amp,rev,halt,flip}}
  localparam logic [14:0] VEC [10] = '{
    {8'h40, 7'h40}, {8'h60, 7'h20}, {8'h10, 7'h10}, {8'h08, 7'h08},
    {8'h04, 7'h04}, {8'h02, 7'h02}, {8'h01, 7'h01}, {8'hFF, 7'h3F},
    {8'hDF, 7'h5F}, {8'h80, 7'h00}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic sel, input logic r, input logic [7:0] d);
    @(negedge clk); cs_n = !sel; rs = r; din = d;
    repeat (2) @(negedge clk); wr_n = 0;
    repeat (3) @(negedge clk); wr_n = 1;
    repeat (6) @(negedge clk); cs_n = 1;
  endtask

  task automatic hr(input logic r, output logic [7:0] d);
    @(negedge clk); cs_n = 0; rs = r;
    repeat (2) @(negedge clk); rd_n = 0;
    repeat (6) @(negedge clk); d = dout;
    rd_n = 1;
    repeat (6) @(negedge clk); cs_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R1 outputs", {25'd0, ovec}, 0);
    chk("R1 dout", {24'd0, dout}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    hw(1, 1, 8'h40);
    chk("R1 index0 after reset", {25'd0, ovec}, 32'h40);

    hw(1, 0, 8'h00);
    for (int i = 0; i < 10; i++) begin
      hw(1, 1, VEC[i][14:7]);
      chk("R3/R4 ctrl decode", {25'd0, ovec}, {25'd0, VEC[i][6:0]});
    end

    hw(1, 1, 8'h00); scan_col = 8'd5; @(negedge clk);
    chk("R10 no flip", {24'd0, seg_idx}, 5);
    hw(1, 1, 8'h01); scan_col = 8'd0; @(negedge clk);
    chk("R10 flip 0", {24'd0, seg_idx}, 159);
    scan_col = 8'd159; @(negedge clk);
    chk("R10 flip 159", {24'd0, seg_idx}, 0);
    scan_col = 8'd37; @(negedge clk);
    chk("R10 flip 37", {24'd0, seg_idx}, 122);

    hw(1, 0, 8'hE0); hw(1, 1, 8'h40);
    chk("R2 upper index bits ignored", {25'd0, ovec}, 32'h40);

    hw(0, 1, 8'h10);
    chk("R11 deselected data write", {25'd0, ovec}, 32'h40);
    hw(0, 0, 8'h01); hw(1, 1, 8'h08);
    chk("R11 deselected index write", {25'd0, ovec}, 32'h08);

    hw(1, 0, 8'h14); hw(1, 1, 8'hFF);
    hw(1, 0, 8'h00);
    chk("R9 unused index write", {25'd0, ovec}, 32'h08);
    hr(1, d);
    chk("R9 read of control", {24'd0, d}, 0);
    hr(0, d);
    chk("R9 read of pointer", {24'd0, d}, 0);
    chk("R9 outputs after reads", {25'd0, ovec}, 32'h08);

    hw(1, 1, 8'h00);
    hw(1, 0, 8'h01); hw(1, 1, 8'h10);
    hw(1, 0, 8'h02); hw(1, 1, 8'hA5); hw(1, 1, 8'h5A);
    hw(1, 0, 8'h01); hw(1, 1, 8'h10); hw(1, 0, 8'h02);
    hr(1, d); chk("R5/R6 first byte", {24'd0, d}, 32'hA5);
    hr(1, d); chk("R6 read increments", {24'd0, d}, 32'h5A);

    hw(1, 0, 8'h00); hw(1, 1, 8'h80);
    hw(1, 0, 8'h01); hw(1, 1, 8'h10); hw(1, 0, 8'h02);
    hr(1, d); chk("R7 rmw read", {24'd0, d}, 32'hA5);
    hw(1, 1, 8'h3C);
    hr(1, d); chk("R7 write then next", {24'd0, d}, 32'h5A);
    hw(1, 0, 8'h01); hw(1, 1, 8'h10); hw(1, 0, 8'h02);
    hr(1, d); chk("R7 modified byte", {24'd0, d}, 32'h3C);
    hr(1, d); chk("R7 read holds address", {24'd0, d}, 32'h3C);

    hw(1, 0, 8'h00); hw(1, 1, 8'h00);
    hw(1, 0, 8'h01); hw(1, 1, 8'hFF); hw(1, 0, 8'h02);
    hw(1, 1, 8'h77); hw(1, 1, 8'h88);
    hw(1, 0, 8'h01); hw(1, 1, 8'hFF); hw(1, 0, 8'h02);
    hr(1, d); chk("R8 last byte", {24'd0, d}, 32'h77);
    hr(1, d); chk("R8 wrapped byte", {24'd0, d}, 32'h88);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule